// File: doc/BRIEF.md
# Three-State Directory Coherence Controller

This block keeps four private direct-mapped first-level caches coherent against one shared memory. It uses a directory and only three line states: Invalid, Exclusive and Shared. A directory entry exists for every memory block. It holds the most recent value written to that block and a one-bit-per-core record of which caches currently hold it. Each core's cache has four lines, and the block keeps a tag and an allocation flag for each line so that it can tell hits from misses.

A core issues one read or write per cycle, with an 8-bit address and a data byte. One cycle later the block returns four things: the requester's new line state, the current value of the block, a pulse mask that invalidates the copies in the other cores, and a hit/miss flag. Modified and Exclusive are folded into one Exclusive state, which either a read or a write can reach. When a remote write kills an Exclusive copy, nothing is written back, because the directory already holds the newest value. Two free-running counters record accepted requests and hits, so the hit ratio can be derived.

Top module: `ies_dir_ctrl`

## Requirements
- R1: After a synchronous reset, rsp_valid, inv_mask, access_count and hit_count are zero. Every block reads as value 0 with no holders, and every cache line is unallocated.
- R2: A read when no other core holds the block returns state Exclusive (2'b01) and the directory value of the block.
- R3: A write returns state Exclusive (2'b01) and the written byte. Its inv_mask holds exactly the previous holders other than the requester, and afterwards the writer is the only holder.
- R4: A read when another core holds the block returns state Shared (2'b10) and the latest value written by any core. The requester is added to the holders.
- R5: A core whose copy was invalidated by a remote write sees the remote value on its next read, with no write-back step.
- R6: The address is split as tag = addr[7:5], index = addr[4:3] and offset = addr[2:0]. Addresses that differ only in the offset name the same block.
- R7: A lookup is a hit when the indexed line of the requesting core is allocated and its tag matches, whatever the coherence state. A miss allocates the line with the new tag.
- R8: When a miss replaces an allocated line with a different tag, the requester is removed from the holders of the old block, and the old block keeps its value.
- R9: req_ready is high once reset is released. rsp_valid is high exactly in the cycle after an accepted request.
- R10: access_count increments on each accepted request and hit_count on each accepted hit. Both are 16-bit counters that wrap modulo 2^16.
- R11: inv_mask is zero for reads and in cycles without a response, and it never contains the requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block accepts requests |
| req_core | input | 2 | Requesting core number |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Response present |
| rsp_state | output | 2 | Requester's new state: 00 Invalid, 01 Exclusive, 10 Shared |
| rsp_data | output | 8 | Current block value |
| rsp_hit | output | 1 | Lookup hit |
| inv_mask | output | 4 | Invalidate pulse, one bit per core |
| access_count | output | 16 | Accepted requests |
| hit_count | output | 16 | Accepted hits |

## Verification
The bench targets a core that hits on a tag match to a line that a remote write has invalidated. A design that tied hits to validity would count that access as a miss, and one that kept stale data would return the old byte. It also replaces a line and then checks that the remaining holder reads back Exclusive. A design that forgot to drop the evicting core would report Shared. Other cases cover offset aliasing, writes that must invalidate several holders at once without touching the writer, a counter run past 2^16, and a mid-run reset that must clear the directory values.

// File: rtl/ies_pkg.sv
package ies_pkg;
  typedef enum logic [1:0] {
    LS_INV  = 2'b00,
    LS_EXCL = 2'b01,
    LS_SHR  = 2'b10
  } line_state_e;
endpackage

// File: rtl/ies_tag_bank.sv
// Tag store of one core's direct-mapped cache: tag RAM plus allocation flags.
module ies_tag_bank #(
  parameter int TAG_W = 3,
  parameter int IDX_W = 2,
  localparam int NLINE = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             fill,
  output logic             hit,
  output logic             present,
  output logic [TAG_W-1:0] cur_tag
);
  logic [TAG_W-1:0] tags [NLINE];
  logic [NLINE-1:0] alloc;

  assign cur_tag = tags[idx];
  assign present = alloc[idx];
  assign hit     = present && (cur_tag == tag);

  always_ff @(posedge clk) begin
    if (rst) alloc <= '0;
    else if (fill) alloc[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill) tags[idx] <= tag;
  end
endmodule

// File: rtl/ies_dir_table.sv
// Directory: holder vector per block, latest value per block.
module ies_dir_table #(
  parameter int BLK_W  = 5,
  parameter int NCORE  = 4,
  parameter int DATA_W = 8,
  localparam int NBLK  = 1 << BLK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BLK_W-1:0]  blk,
  output logic [NCORE-1:0]  sharers,
  output logic [DATA_W-1:0] data,
  input  logic              set_en,
  input  logic [NCORE-1:0]  set_val,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              drop_en,
  input  logic [BLK_W-1:0]  drop_blk,
  input  logic [NCORE-1:0]  drop_mask
);
  logic [NCORE-1:0]  shr [NBLK];
  logic [NBLK-1:0]   written;
  logic [DATA_W-1:0] mem [NBLK];

  assign sharers = shr[blk];
  assign data    = written[blk] ? mem[blk] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < NBLK; b++) shr[b] <= '0;
    end else begin
      if (drop_en) shr[drop_blk] <= shr[drop_blk] & ~drop_mask;
      if (set_en)  shr[blk] <= set_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) written <= '0;
    else if (wr_en) written[blk] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[blk] <= wr_data;
  end
endmodule

// File: rtl/ies_event_ctr.sv
// Wrapping event counter.
module ies_event_ctr #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else if (inc) count <= count + W'(1);
  end
endmodule

// File: rtl/ies_dir_ctrl.sv
module ies_dir_ctrl
  import ies_pkg::*;
#(
  parameter int NCORE  = 4,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int TAG_W  = 3,
  parameter int IDX_W  = 2,
  parameter int CNT_W  = 16,
  localparam int CORE_W = $clog2(NCORE)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [CORE_W-1:0] req_core,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [1:0]        rsp_state,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic [NCORE-1:0]  inv_mask,
  output logic [CNT_W-1:0]  access_count,
  output logic [CNT_W-1:0]  hit_count
);
  localparam int OFF_W = ADDR_W - TAG_W - IDX_W;
  localparam int BLK_W = TAG_W + IDX_W;

  logic              accept;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [BLK_W-1:0]  blk;
  logic [NCORE-1:0]  self_oh;

  assign accept  = req_valid && req_ready;
  assign idx     = req_addr[OFF_W +: IDX_W];
  assign tag     = req_addr[ADDR_W-1 -: TAG_W];
  assign blk     = req_addr[ADDR_W-1 -: BLK_W];
  assign self_oh = {{(NCORE-1){1'b0}}, 1'b1} << req_core;

  // Per-core tag banks
  logic [NCORE-1:0] hit_v;
  logic [NCORE-1:0] present_v;
  logic [TAG_W-1:0] tag_v [NCORE];

  for (genvar g = 0; g < NCORE; g++) begin : g_bank
    logic fill_g;
    assign fill_g = accept && (req_core == CORE_W'(g)) && !hit_v[g];
    ies_tag_bank #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .idx     (idx),
      .tag     (tag),
      .fill    (fill_g),
      .hit     (hit_v[g]),
      .present (present_v[g]),
      .cur_tag (tag_v[g])
    );
  end

  logic             hit_sel;
  logic             evict;
  logic [BLK_W-1:0] drop_blk;

  assign hit_sel  = hit_v[req_core];
  assign evict    = accept && present_v[req_core] && !hit_sel;
  assign drop_blk = {tag_v[req_core], idx};

  // Directory
  logic [NCORE-1:0]  dir_shr;
  logic [DATA_W-1:0] dir_data;
  logic [NCORE-1:0]  others;
  logic [NCORE-1:0]  nx_shr;
  logic [NCORE-1:0]  nx_inv;
  logic [DATA_W-1:0] nx_data;
  line_state_e       nx_state;

  assign others = dir_shr & ~self_oh;

  always_comb begin
    if (req_write) begin
      nx_state = LS_EXCL;
      nx_shr   = self_oh;
      nx_data  = req_wdata;
      nx_inv   = others;
    end else begin
      nx_state = (others == '0) ? LS_EXCL : LS_SHR;
      nx_shr   = dir_shr | self_oh;
      nx_data  = dir_data;
      nx_inv   = '0;
    end
  end

  ies_dir_table #(.BLK_W(BLK_W), .NCORE(NCORE), .DATA_W(DATA_W)) u_dir (
    .clk       (clk),
    .rst       (rst),
    .blk       (blk),
    .sharers   (dir_shr),
    .data      (dir_data),
    .set_en    (accept),
    .set_val   (nx_shr),
    .wr_en     (accept && req_write),
    .wr_data   (req_wdata),
    .drop_en   (evict),
    .drop_blk  (drop_blk),
    .drop_mask (self_oh)
  );

  // Counters
  ies_event_ctr #(.W(CNT_W)) u_acc_ctr (
    .clk (clk), .rst (rst), .inc (accept), .count (access_count)
  );
  ies_event_ctr #(.W(CNT_W)) u_hit_ctr (
    .clk (clk), .rst (rst), .inc (accept && hit_sel), .count (hit_count)
  );

  // Registered response
  always_ff @(posedge clk) begin
    if (rst) begin
      req_ready <= 1'b0;
      rsp_valid <= 1'b0;
      inv_mask  <= '0;
      rsp_state <= LS_INV;
      rsp_data  <= '0;
      rsp_hit   <= 1'b0;
    end else begin
      req_ready <= 1'b1;
      rsp_valid <= accept;
      inv_mask  <= accept ? nx_inv : '0;
      if (accept) begin
        rsp_state <= nx_state;
        rsp_data  <= nx_data;
        rsp_hit   <= hit_sel;
      end
    end
  end
endmodule

// File: rtl/ies_dir_ctrl_chk.sv
module ies_dir_ctrl_chk #(
  parameter int NCORE  = 4,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  localparam int CORE_W = $clog2(NCORE)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [CORE_W-1:0] req_core,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [1:0]        rsp_state,
  input logic [DATA_W-1:0] rsp_data,
  input logic              rsp_hit,
  input logic [NCORE-1:0]  inv_mask,
  input logic [CNT_W-1:0]  access_count,
  input logic [CNT_W-1:0]  hit_count
);
  p_rsp_after_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_ready) |=> !rsp_valid);

  p_write_excl_r3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_write) |=>
      (rsp_state == 2'b01) && (rsp_data == $past(req_wdata)));

  p_legal_state_r2: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_state == 2'b01 || rsp_state == 2'b10));

  p_inv_not_self_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !inv_mask[$past(req_core)]);

  p_read_no_inv_r11: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !req_write) |=> (inv_mask == '0));

  p_idle_no_inv_r11: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> (inv_mask == '0));

  p_access_step_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (access_count == $past(access_count) + CNT_W'(1)));

  p_hit_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_hit) |-> (hit_count == $past(hit_count)));
endmodule

bind ies_dir_ctrl ies_dir_ctrl_chk #(.NCORE(NCORE), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_core     (req_core),
  .req_write    (req_write),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .rsp_state    (rsp_state),
  .rsp_data     (rsp_data),
  .rsp_hit      (rsp_hit),
  .inv_mask     (inv_mask),
  .access_count (access_count),
  .hit_count    (hit_count)
);

// File: tb/test_ies_dir_ctrl.sv
module test_ies_dir_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_core = '0;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic [1:0] rsp_state;
  logic [7:0] rsp_data;
  logic       rsp_hit;
  logic [3:0] inv_mask;
  logic [15:0] access_count;
  logic [15:0] hit_count;

  int n_chk = 0;
  int n_fail = 0;

  ies_dir_ctrl i_ies_dir_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_core(req_core), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_state(rsp_state),
    .rsp_data(rsp_data), .rsp_hit(rsp_hit), .inv_mask(inv_mask),
    .access_count(access_count), .hit_count(hit_count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // {core, write, addr, wdata, exp_state, exp_data, exp_hit, exp_inv}
  // Blocks: A=0x46 (tag2 idx0), B=0x23 (tag1 idx0), C=0xE6 (tag7 idx0),
  //         D=0x29 (tag1 idx1), E=0x34 (tag1 idx2)
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 1'b0, 8'h46, 8'h00, 2'b01, 8'h00, 1'b0, 4'b0000}, // R2 first read
    {2'd1, 1'b1, 8'h46, 8'h12, 2'b01, 8'h12, 1'b0, 4'b0001}, // R3
    {2'd2, 1'b1, 8'h46, 8'h29, 2'b01, 8'h29, 1'b0, 4'b0010}, // R3
    {2'd0, 1'b0, 8'h46, 8'h00, 2'b10, 8'h29, 1'b1, 4'b0000}, // R5 R7 hit on invalid line
    {2'd0, 1'b0, 8'h47, 8'h00, 2'b10, 8'h29, 1'b1, 4'b0000}, // R6 offset alias
    {2'd3, 1'b1, 8'h46, 8'h30, 2'b01, 8'h30, 1'b0, 4'b0101}, // R3 two holders
    {2'd0, 1'b0, 8'h23, 8'h00, 2'b01, 8'h00, 1'b0, 4'b0000}, // R7 miss replace
    {2'd2, 1'b0, 8'h46, 8'h00, 2'b10, 8'h30, 1'b1, 4'b0000}, // R4
    {2'd2, 1'b0, 8'hE6, 8'h00, 2'b01, 8'h00, 1'b0, 4'b0000}, // R8 core2 drops A
    {2'd3, 1'b0, 8'h46, 8'h00, 2'b01, 8'h30, 1'b1, 4'b0000}, // R8 sole holder again
    {2'd1, 1'b0, 8'h46, 8'h00, 2'b10, 8'h30, 1'b1, 4'b0000}, // R4 R5
    {2'd1, 1'b1, 8'h29, 8'h55, 2'b01, 8'h55, 1'b0, 4'b0000}, // R3
    {2'd0, 1'b0, 8'h29, 8'h00, 2'b10, 8'h55, 1'b0, 4'b0000}, // R4 miss but shared
    {2'd3, 1'b1, 8'h46, 8'h77, 2'b01, 8'h77, 1'b1, 4'b0010}, // R3 R11 write hit
    {2'd1, 1'b0, 8'h46, 8'h00, 2'b10, 8'h77, 1'b1, 4'b0000}, // R5
    {2'd2, 1'b1, 8'h34, 8'hA5, 2'b01, 8'hA5, 1'b0, 4'b0000}, // R3
    {2'd2, 1'b0, 8'h35, 8'h00, 2'b01, 8'hA5, 1'b1, 4'b0000}, // R6 R2
    {2'd0, 1'b1, 8'h23, 8'h01, 2'b01, 8'h01, 1'b1, 4'b0000}  // R3 R7
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] core, input logic wr, input logic [7:0] addr,
                      input logic [7:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_core = core; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(req_ready == 1'b1, "R9 req_ready after reset", 32'(req_ready), 1);
    check(access_count == 0 && hit_count == 0, "R1 counters cleared",
          {access_count, hit_count}, 0);
    check(inv_mask == 0, "R1 inv_mask cleared", 32'(inv_mask), 0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [33:0] v;
      logic [14:0] act;
      v = VEC[i];
      send(v[33:32], v[31], v[30:23], v[22:15]);
      act = {rsp_state, rsp_data, rsp_hit, inv_mask};
      check(rsp_valid == 1'b1, "R9 rsp_valid after request", 32'(rsp_valid), 1);
      check(act == v[14:0], $sformatf("R2/R3/R4/R5/R6/R7/R8/R11 vector %0d", i),
            32'(act), 32'(v[14:0]));
    end

    @(negedge clk);
    check(rsp_valid == 1'b0, "R9 no response when idle", 32'(rsp_valid), 0);
    check(inv_mask == 0, "R11 inv_mask idle", 32'(inv_mask), 0);
    check(access_count == 16'd18, "R10 access count", 32'(access_count), 18);
    check(hit_count == 16'd9, "R10 hit count", 32'(hit_count), 9);

    // Counter wrap: 65536 back-to-back hits (core3 reads A)
    @(negedge clk);
    req_valid = 1'b1; req_core = 2'd3; req_write = 1'b0; req_addr = 8'h46;
    repeat (65536) @(negedge clk);
    req_valid = 1'b0;
    check(rsp_state == 2'b10 && rsp_data == 8'h77, "R4 streamed read",
          {rsp_state, rsp_data}, {2'b10, 8'h77});
    check(access_count == 16'd18, "R10 access wrap", 32'(access_count), 18);
    check(hit_count == 16'd9, "R10 hit wrap", 32'(hit_count), 9);

    // Mid-run reset clears the directory and tags
    do_reset();
    check(access_count == 0 && hit_count == 0, "R1 counters after reset",
          {access_count, hit_count}, 0);
    send(2'd0, 1'b0, 8'h46, 8'h00);
    check({rsp_state, rsp_data, rsp_hit} == {2'b01, 8'h00, 1'b0},
          "R1 directory value after reset", {rsp_state, rsp_data, rsp_hit},
          {2'b01, 8'h00, 1'b0});

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule